// File: doc/BRIEF.md
# Bridge Address Forwarding Decoder

This block sits beside the two ports of a bus-to-bus bridge and answers one question for every transaction either side presents: should the bridge claim it and carry it across? The caller pulses a request strobe together with the address, the transaction kind (memory or I/O) and the travel direction. One clock later the block returns a valid flag and a claim bit. The decision is built from the programmed I/O and memory windows. Two legacy modifiers then act on it: an ISA alias mask for the low 64 KB of I/O space, and a fixed VGA decode for the display memory hole and the display I/O ports.

Downstream traffic (primary to secondary) is claimed when its address falls inside the window for its kind. Upstream traffic is claimed when the address lies outside that window. The ISA mask and the VGA decode each reverse this result for the addresses they cover, and the VGA decode wins where the two overlap. A separate small path turns a rising edge on the secondary system-error line into a one-cycle fatal or non-fatal error event. That path runs only while its forward enable is set.

Top module: `fwd_decoder`

## Requirements
- R1: With `isa_en`=0 and `vga_en`=0, a downstream (`dir_up`=0) I/O request (`is_io`=1) is claimed exactly when `io_base` <= addr <= `io_limit`, with both bounds inclusive.
- R2: With `isa_en`=1, a downstream I/O request inside the I/O window is not claimed when addr[31:16]=0 and addr[9:8]!=00, unless it is a VGA match (R6). Windowed addresses with addr[9:8]=00 are still claimed.
- R3: The ISA mask applies only when addr[31:16]=0. Windowed I/O above 64 KB is claimed downstream, whatever the value of addr[9:8].
- R4: An upstream (`dir_up`=1) request is claimed exactly when its address lies outside the window for its kind. Two exceptions apply: addresses that the ISA mask of R2 blocks downstream are claimed upstream, and VGA matches are never claimed upstream.
- R5: With `vga_en`=1, memory addresses 000A_0000h to 000B_FFFFh are claimed downstream and refused upstream, independent of the memory window.
- R6: With `vga_en`=1, an I/O address with addr[31:16]=0 and addr[9:0] in 3B0h..3BBh or 3C0h..3DFh is claimed downstream and refused upstream. Bits 15:10 are ignored, and this rule takes precedence over the ISA mask.
- R7: A downstream memory request (`is_io`=0) that is not a VGA match is claimed exactly when `mem_base` <= addr <= `mem_limit`.
- R8: A window whose limit is below its base is empty. No I/O is claimed downstream except VGA matches.
- R9: `fwd_valid` is high for exactly the cycle after each cycle in which `req` is sampled high. `fwd_claim` is 0 whenever `fwd_valid` is 0. Synchronous active-low reset clears both.
- R10: With `serr_fwd_en`=0, `err_fatal` and `err_nonfatal` stay 0. With `serr_fwd_en`=1, each rising edge of `serr_in` yields exactly one single-cycle pulse, in the cycle after the edge is sampled.
- R11: `sev_fatal`=1 sends the error pulse to `err_fatal`, and `sev_fatal`=0 sends it to `err_nonfatal`. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Decision request strobe |
| dir_up | input | 1 | 0 = primary to secondary, 1 = secondary to primary |
| is_io | input | 1 | 1 = I/O transaction, 0 = memory |
| addr | input | 32 | Transaction address |
| io_base | input | 32 | I/O window lower bound (inclusive) |
| io_limit | input | 32 | I/O window upper bound (inclusive) |
| mem_base | input | 32 | Memory window lower bound (inclusive) |
| mem_limit | input | 32 | Memory window upper bound (inclusive) |
| isa_en | input | 1 | Enable ISA alias masking |
| vga_en | input | 1 | Enable VGA legacy decode |
| serr_in | input | 1 | Secondary system-error input |
| serr_fwd_en | input | 1 | Enable error forwarding |
| sev_fatal | input | 1 | Severity select: 1 fatal, 0 non-fatal |
| fwd_valid | output | 1 | Decision valid, one cycle after req |
| fwd_claim | output | 1 | Forward/claim decision |
| err_fatal | output | 1 | Fatal error event pulse |
| err_nonfatal | output | 1 | Non-fatal error event pulse |

## Verification
The embedded assertions check the following on every cycle:
- the one-cycle valid timing and the rule that a claim only appears with valid;
- that a VGA hit always wins in both directions;
- that an ISA-masked downstream access is never claimed unless VGA covers it;
- that error pulses stay gated and mutually exclusive.

Other behaviours can only be shown by the bench sweeps:
- the exact inclusive window edges;
- the alias behaviour of bits 15:10;
- the 64 KB limit on the ISA mask;
- the empty-window case;
- the single-pulse-per-edge behaviour.

The sweeps step across every low I/O offset around the VGA ports and across the memory boundaries, and compare each result with an arithmetic model.

// File: rtl/fwd_decoder_pkg.sv
// Package: shared types for the bridge forwarding decoder.
// Assumes: address width is at least 20 bits, so the VGA memory hole fits.
package fwd_decoder_pkg;

    // Direction of travel across the bridge
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Per-request classification flags produced by the sub-decoders
    typedef struct packed {
        logic in_win;
        logic isa_blk;
        logic vga_hit;
    } dec_flags_t;

    // Apply the direction rule to the classification flags
    function automatic logic claim_of(dir_e dir, dec_flags_t f);
        if (dir == DIR_DOWN) begin
            return f.vga_hit | (f.in_win & ~f.isa_blk);
        end
        return ~f.vga_hit & (~f.in_win | f.isa_blk);
    endfunction

endpackage

// File: rtl/range_check.sv
// Module: range_check
// Purpose: inclusive lower/upper bound compare of an address.
// Assumes: lo > hi describes an empty window; no match is reported then.
module range_check #(
    parameter int W = 32
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] a,
    output logic         hit
);
    // Both bounds inclusive; an inverted window never matches
    always_comb hit = (a >= lo) && (a <= hi);
endmodule

// File: rtl/isa_alias_mask.sv
// Module: isa_alias_mask
// Purpose: flags windowed I/O in the low 64 KB whose offset lies in the
// upper 768 bytes of a 1 KB block (block-position bits not 00).
// Assumes: caller supplies the low-64K qualifier and the window hit.
module isa_alias_mask (
    input  logic       isa_en,
    input  logic       is_io,
    input  logic       low64k,
    input  logic       in_io_win,
    input  logic [1:0] blk_pos,
    output logic       blk
);
    // Mask is active only for enabled, low, windowed I/O
    always_comb blk = isa_en && is_io && low64k && in_io_win && (blk_pos != 2'b00);
endmodule

// File: rtl/vga_legacy_match.sv
// Module: vga_legacy_match
// Purpose: recognises the fixed VGA memory hole and display I/O ports.
// Assumes: I/O matching ignores bits 15:10, so every ISA alias matches.
module vga_legacy_match #(
    parameter int ADDR_W = 32
) (
    input  logic              vga_en,
    input  logic              is_io,
    input  logic              low64k,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] MEM_LO   = ADDR_W'(32'h000A_0000);
    localparam logic [ADDR_W-1:0] MEM_HI   = ADDR_W'(32'h000B_FFFF);
    localparam logic [9:0]        MONO_LO  = 10'h3B0;
    localparam logic [9:0]        MONO_HI  = 10'h3BB;
    localparam logic [9:0]        COLOR_LO = 10'h3C0;
    localparam logic [9:0]        COLOR_HI = 10'h3DF;

    logic mem_hit;
    logic io_hit;

    // Memory hole compare on the full address
    always_comb mem_hit = (addr >= MEM_LO) && (addr <= MEM_HI);

    // Port compare on the 10-bit offset only, low 64 KB required
    always_comb io_hit = low64k &&
                         (((addr[9:0] >= MONO_LO)  && (addr[9:0] <= MONO_HI)) ||
                          ((addr[9:0] >= COLOR_LO) && (addr[9:0] <= COLOR_HI)));

    // Select by transaction kind and gate by enable
    always_comb hit = vga_en && (is_io ? io_hit : mem_hit);
endmodule

// File: rtl/err_forward.sv
// Module: err_forward
// Purpose: converts a rising edge of the secondary error line into a
// one-cycle fatal or non-fatal pulse, gated by the forward enable.
// Assumes: serr_in is synchronous to clk.
module err_forward (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_in,
    input  logic fwd_en,
    input  logic sev_fatal,
    output logic err_fatal,
    output logic err_nonfatal
);
    logic serr_q;
    logic rise;

    // Edge detector on the sampled error line
    always_comb rise = serr_in & ~serr_q;

    // Remember last error level and register the routed pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serr_q       <= 1'b0;
            err_fatal    <= 1'b0;
            err_nonfatal <= 1'b0;
        end else begin
            serr_q       <= serr_in;
            err_fatal    <= fwd_en & rise & sev_fatal;
            err_nonfatal <= fwd_en & rise & ~sev_fatal;
        end
    end

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fatal && err_nonfatal));                                         // R11
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_en |=> !(err_fatal || err_nonfatal));                             // R10
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_fatal || err_nonfatal) |=> !(err_fatal || err_nonfatal));         // R10
endmodule

// File: rtl/fwd_decoder.sv
// Module: fwd_decoder (top)
// Purpose: registered claim/forward decision for bridge transactions,
// combining base/limit windows with ISA alias masking and VGA legacy
// decode, plus the gated secondary-error forwarding path.
// Assumes: ADDR_W > 16; inputs are stable in the cycle req is high.
module fwd_decoder
    import fwd_decoder_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              dir_up,
    input  logic              is_io,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] io_base,
    input  logic [ADDR_W-1:0] io_limit,
    input  logic [ADDR_W-1:0] mem_base,
    input  logic [ADDR_W-1:0] mem_limit,
    input  logic              isa_en,
    input  logic              vga_en,
    input  logic              serr_in,
    input  logic              serr_fwd_en,
    input  logic              sev_fatal,
    output logic              fwd_valid,
    output logic              fwd_claim,
    output logic              err_fatal,
    output logic              err_nonfatal
);
    localparam int HI_W = ADDR_W - 16;

    logic       low64k;
    logic       io_win_hit;
    logic       mem_win_hit;
    dec_flags_t flags;
    logic       claim_d;

    // Upper address bits all zero means the low 64 KB of I/O space
    always_comb low64k = (addr[ADDR_W-1:16] == {HI_W{1'b0}});

    range_check #(.W(ADDR_W)) u_io_win (
        .lo(io_base), .hi(io_limit), .a(addr), .hit(io_win_hit)
    );

    range_check #(.W(ADDR_W)) u_mem_win (
        .lo(mem_base), .hi(mem_limit), .a(addr), .hit(mem_win_hit)
    );

    isa_alias_mask u_isa (
        .isa_en(isa_en), .is_io(is_io), .low64k(low64k),
        .in_io_win(io_win_hit), .blk_pos(addr[9:8]), .blk(flags.isa_blk)
    );

    vga_legacy_match #(.ADDR_W(ADDR_W)) u_vga (
        .vga_en(vga_en), .is_io(is_io), .low64k(low64k),
        .addr(addr), .hit(flags.vga_hit)
    );

    // Pick the window matching the transaction kind
    always_comb flags.in_win = is_io ? io_win_hit : mem_win_hit;

    // Direction rule with ISA and VGA exceptions
    always_comb claim_d = claim_of(dir_e'(dir_up), flags);

    // Register the decision for one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_claim <= 1'b0;
        end else begin
            fwd_valid <= req;
            fwd_claim <= req & claim_d;
        end
    end

    err_forward u_err (
        .clk(clk), .rst_n(rst_n), .serr_in(serr_in), .fwd_en(serr_fwd_en),
        .sev_fatal(sev_fatal), .err_fatal(err_fatal), .err_nonfatal(err_nonfatal)
    );

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> fwd_valid);                                                    // R9
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !fwd_valid);                                                  // R9
    AST_CLAIM_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_claim |-> fwd_valid);                                              // R9
    AST_VGA_DOWN_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dir_up && flags.vga_hit) |=> fwd_claim);                      // R6
    AST_VGA_UP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && dir_up && flags.vga_hit) |=> !fwd_claim);                      // R5
    AST_ISA_DOWN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !dir_up && flags.isa_blk && !flags.vga_hit) |=> !fwd_claim);   // R2
endmodule

// File: tb/test_fwd_decoder.sv
// Bench: near-exhaustive sweeps of the forwarding decoder against an
// arithmetic model derived from the requirements.
module test_fwd_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, dir_up = 1'b0, is_io = 1'b0;
    logic [31:0] addr = '0, io_base = '0, io_limit = '0, mem_base = '0, mem_limit = '0;
    logic        isa_en = 1'b0, vga_en = 1'b0;
    logic        serr_in = 1'b0, serr_fwd_en = 1'b0, sev_fatal = 1'b0;
    logic        fwd_valid, fwd_claim, err_fatal, err_nonfatal;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_decoder i_fwd_decoder (
        .clk(clk), .rst_n(rst_n), .req(req), .dir_up(dir_up), .is_io(is_io),
        .addr(addr), .io_base(io_base), .io_limit(io_limit),
        .mem_base(mem_base), .mem_limit(mem_limit),
        .isa_en(isa_en), .vga_en(vga_en), .serr_in(serr_in),
        .serr_fwd_en(serr_fwd_en), .sev_fatal(sev_fatal),
        .fwd_valid(fwd_valid), .fwd_claim(fwd_claim),
        .err_fatal(err_fatal), .err_nonfatal(err_nonfatal)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model of the requirements
    function automatic logic model(logic up, logic io, logic [31:0] a);
        logic win, low, isa, vga;
        win = io ? (a >= io_base && a <= io_limit) : (a >= mem_base && a <= mem_limit);
        low = (a[31:16] == 16'h0);
        isa = isa_en && io && low && win && (a[9:8] != 2'b00);
        if (io)
            vga = vga_en && low && ((a[9:0] >= 10'h3B0 && a[9:0] <= 10'h3BB) ||
                                    (a[9:0] >= 10'h3C0 && a[9:0] <= 10'h3DF));
        else
            vga = vga_en && (a >= 32'hA0000) && (a <= 32'hBFFFF);
        if (!up) return vga || (win && !isa);
        return !vga && (!win || isa);
    endfunction

    // One request; the decision is registered at the next edge, sampled after it
    task automatic one_req(string tag, logic up, logic io, logic [31:0] a);
        logic exp;
        @(negedge clk);
        dir_up = up; is_io = io; addr = a; req = 1'b1;
        exp = model(up, io, a);
        @(negedge clk);
        req = 1'b0;
        check(tag, {31'h0, fwd_valid}, 32'h1, "valid after req");
        check(tag, {31'h0, fwd_claim}, {31'h0, exp}, $sformatf("claim addr=%0h up=%0b io=%0b", a, up, io));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", {31'h0, fwd_valid}, 32'h0, "valid in reset");
        check("R9", {31'h0, fwd_claim}, 32'h0, "claim in reset");
        check("R10", {31'h0, err_fatal | err_nonfatal}, 32'h0, "err in reset");
        rst_n = 1'b1;

        io_base = 32'h200; io_limit = 32'h1BFF;
        mem_base = 32'hB0000; mem_limit = 32'hDFFFF;

        // I/O sweep: ISA/VGA combos, both directions, offsets with alias bits
        for (int m = 0; m < 4; m++) begin
            isa_en = m[0]; vga_en = m[1];
            for (int d = 0; d < 2; d++) begin
                for (int off = 0; off < 2; off++) begin
                    for (int lo = 32'h300; lo < 32'h500; lo++) begin
                        string tag;
                        tag = (m[1] && ((lo >= 32'h3B0 && lo <= 32'h3BB) || (lo >= 32'h3C0 && lo <= 32'h3DF)))
                              ? "R6" : (d == 1) ? "R4" : m[0] ? "R2" : "R1";
                        one_req(tag, d[0], 1'b1, 32'(lo + off * 32'h1400));
                    end
                end
            end
        end

        // I/O window edges
        isa_en = 1'b0; vga_en = 1'b0;
        one_req("R1", 1'b0, 1'b1, 32'h1FF);
        one_req("R1", 1'b0, 1'b1, 32'h200);
        one_req("R1", 1'b0, 1'b1, 32'h1BFF);
        one_req("R1", 1'b0, 1'b1, 32'h1C00);

        // Memory sweep across the VGA hole and the window edges
        for (int m = 0; m < 2; m++) begin
            vga_en = m[0];
            for (int d = 0; d < 2; d++) begin
                for (int a = 32'h9F000; a <= 32'hE1000; a += 32'h800)
                    one_req(m ? "R5" : "R7", d[0], 1'b0, 32'(a));
                one_req("R5", d[0], 1'b0, 32'h9FFFF);
                one_req("R5", d[0], 1'b0, 32'hA0000);
                one_req("R5", d[0], 1'b0, 32'hBFFFF);
                one_req("R7", d[0], 1'b0, 32'hAFFFF);
                one_req("R7", d[0], 1'b0, 32'hC0000);
                one_req("R7", d[0], 1'b0, 32'hDFFFF);
                one_req("R7", d[0], 1'b0, 32'hE0000);
            end
        end

        // R3: ISA mask limited to the low 64 KB
        io_base = 32'h0; io_limit = 32'h1FFFF; isa_en = 1'b1; vga_en = 1'b0;
        for (int a = 32'h10000; a < 32'h11000; a += 4) one_req("R3", 1'b0, 1'b1, 32'(a));
        one_req("R3", 1'b0, 1'b1, 32'h0300);
        one_req("R3", 1'b1, 1'b1, 32'h10300);

        // R8: inverted window is empty, VGA still claimed
        io_base = 32'h800; io_limit = 32'h400; vga_en = 1'b1;
        for (int d = 0; d < 2; d++)
            for (int lo = 32'h300; lo < 32'h500; lo++) one_req("R8", d[0], 1'b1, 32'(lo));

        // R9: back-to-back requests and single-cycle valid
        @(negedge clk); req = 1'b1; addr = 32'h3C0; is_io = 1'b1; dir_up = 1'b0;
        @(negedge clk);
        check("R9", {31'h0, fwd_valid}, 32'h1, "valid first of pair");
        @(negedge clk); req = 1'b0;
        check("R9", {31'h0, fwd_valid}, 32'h1, "valid second of pair");
        @(negedge clk);
        check("R9", {31'h0, fwd_valid}, 32'h0, "valid dropped");
        check("R9", {31'h0, fwd_claim}, 32'h0, "claim dropped");
        // R9: reset during a request
        req = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        check("R9", {31'h0, fwd_valid}, 32'h0, "valid under reset");
        req = 1'b0; rst_n = 1'b1;

        // R10: disabled forwarding produces nothing
        serr_fwd_en = 1'b0; sev_fatal = 1'b1;
        @(negedge clk); serr_in = 1'b1;
        @(negedge clk);
        check("R10", {30'h0, err_fatal, err_nonfatal}, 32'h0, "disabled pulse");
        @(negedge clk); serr_in = 1'b0;
        @(negedge clk);

        // R10/R11: enabled, fatal then non-fatal
        serr_fwd_en = 1'b1;
        for (int s = 0; s < 2; s++) begin
            sev_fatal = ~s[0];
            serr_in = 1'b1;
            @(negedge clk);
            check("R11", {30'h0, err_fatal, err_nonfatal},
                  s ? 32'h1 : 32'h2, "routed pulse");
            @(negedge clk);
            check("R10", {30'h0, err_fatal, err_nonfatal}, 32'h0, "single pulse while held");
            @(negedge clk);
            check("R10", {30'h0, err_fatal, err_nonfatal}, 32'h0, "no repeat");
            serr_in = 1'b0;
            @(negedge clk);
            check("R10", {30'h0, err_fatal, err_nonfatal}, 32'h0, "no pulse on fall");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule